// File: doc/BRIEF.md
# Per-Bit Phase-Selecting Bus Receiver

This block is the receive end of a parallel bus whose bit lanes are not delay-matched to one another. Each lane gets its own timing, so every lane is trained and started on its own. After reset the sender drives each lane low and then, as its first action, raises every lane once (the training rise). The receiver watches each lane on both the rising and the falling edge of its local clock. Where that first rise falls inside the clock period decides which edge samples the lane from then on. The choice stays fixed until the next reset.

The cycle that detects a lane's training rise also starts that lane's private write pointer. Each following symbol goes into a small per-lane ring buffer. One read pointer is shared by all lanes. It starts at a fixed count of clock cycles after reset release. Every output word therefore holds bits that were sent in the same symbol slot, and it appears at a fixed, predictable cycle, whatever the individual lane delays are. A per-lane ready flag shows which lanes have trained. The output word is flagged valid only once every lane is ready.

Top module: `lprx_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `out_word`, `lane_ready` and `lane_edge_fall` are all zero.
- R2: A lane is ignored until it has been sampled low at a rising edge and then goes high. A lane that is held high from reset never becomes ready.
- R3: Edge 0 is the first rising edge with reset low. If a lane's training rise lands in the first half of a clock period (after a rising edge, before the next falling edge), `lane_edge_fall[i]` becomes 1, meaning falling-edge sampling. If the rise lands in the second half, the bit stays 0, meaning rising-edge sampling.
- R4: A training rise that arrives d picoseconds after edge 0 sets `lane_ready[i]` at rising edge floor(d/period)+1. The flag then stays set until reset.
- R5: Once a lane is ready, its `lane_edge_fall` bit does not change before reset, even if the lane's arrival time later moves into the other half-period.
- R6: The symbols that follow the training rise are placed in the output word by lane position. Bit i of each word is lane i's symbol, and all bits of one word come from the same symbol slot. The training symbol itself is not emitted.
- R7: If every lane's training rise arrives less than LATENCY-2 periods after edge 0, `out_valid` first rises after edge LATENCY and carries payload symbol 0. Payload symbol j appears after edge LATENCY+j.
- R8: `out_valid` stays low while any lane is not ready.
- R9: Once `out_valid` is high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_in | input | LANES | One serial bit per lane, each with its own unknown delay |
| out_word | output | LANES | Aligned word, bit i from lane i |
| out_valid | output | 1 | The word on `out_word` is a payload symbol |
| lane_ready | output | LANES | Lane i has seen its training rise |
| lane_edge_fall | output | LANES | 1: lane i is sampled on the falling edge; 0: on the rising edge |

## Verification
The tightest collision is between a late lane's first buffer write and the shared read pointer's first read of that same slot. With the latest legal arrival, the lane locks at edge LATENCY-2. It writes payload 0 at edge LATENCY-1, and the read takes it at edge LATENCY. A directed case puts one lane exactly there, while the other lanes arrive early in both half-periods. Every word is then compared bit by bit against the sent payload at its fixed cycle, so a write one cycle late, or a read one cycle early, shows up as a mixed word.

// File: rtl/lprx_pkg.sv
`timescale 1ns/1ps
package lprx_pkg;

    // Training state of one lane
    typedef enum logic [1:0] {
        LN_WAIT_LOW = 2'd0,   // lane not yet seen low at a rising edge
        LN_ARMED    = 2'd1,   // seen low, watching for the training rise
        LN_LOCKED   = 2'd2    // edge chosen, write pointer running
    } lane_st_e;

endpackage

// File: rtl/lprx_lane_detect.sv
`timescale 1ns/1ps
module lprx_lane_detect
    import lprx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic ready,
    output logic edge_fall,
    output logic wr_en,
    output logic sel_bit
);

    typedef struct packed {
        lane_st_e st;
        logic     rise;   // lane value at the previous rising edge
        logic     fall;   // 1: falling-edge sampling chosen
    } det_t;

    det_t det_d, det_q;
    logic neg_q;          // lane value at the latest falling edge

    // Half-period sample, taken on the falling edge
    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= din;
    end

    always_comb begin
        det_d      = det_q;
        det_d.rise = din;
        case (det_q.st)
            LN_WAIT_LOW: begin
                if (!din) det_d.st = LN_ARMED;
            end
            LN_ARMED: begin
                if (neg_q && !det_q.rise) begin
                    // rise landed before mid-period
                    det_d.st   = LN_LOCKED;
                    det_d.fall = 1'b1;
                end else if (din && !det_q.rise) begin
                    // rise landed after mid-period
                    det_d.st   = LN_LOCKED;
                    det_d.fall = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q.st   <= LN_WAIT_LOW;
            det_q.rise <= 1'b0;
            det_q.fall <= 1'b0;
        end else begin
            det_q <= det_d;
        end
    end

    assign ready     = (det_q.st == LN_LOCKED);
    assign edge_fall = det_q.fall;
    assign wr_en     = (det_q.st == LN_LOCKED);
    assign sel_bit   = det_q.fall ? neg_q : din;

endmodule

// File: rtl/lprx_lane_buf.sv
`timescale 1ns/1ps
module lprx_lane_buf #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             rd_bit
);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [PTR_W-1:0] wptr;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (wr_en) begin
            buf_d.mem[buf_q.wptr] = wr_bit;
            if (buf_q.wptr == PTR_W'(DEPTH - 1)) buf_d.wptr = '0;
            else                                buf_d.wptr = buf_q.wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q.mem  <= '0;
            buf_q.wptr <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_bit = buf_q.mem[rd_ptr];

endmodule

// File: rtl/lprx_read_ctrl.sv
`timescale 1ns/1ps
module lprx_read_ctrl #(
    parameter int LANES   = 8,
    parameter int LATENCY = 8,
    parameter int DEPTH   = 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(LATENCY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             all_ready,
    input  logic [LANES-1:0] rd_bits,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LANES-1:0] out_word,
    output logic             out_valid
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] rptr;
        logic [LANES-1:0] word;
        logic             valid;
    } rd_t;

    rd_t rd_d, rd_q;
    logic at_offset;

    assign at_offset = (rd_q.cnt == CNT_W'(LATENCY));

    always_comb begin
        rd_d = rd_q;
        if (!at_offset) rd_d.cnt = rd_q.cnt + 1'b1;
        if (at_offset && all_ready) begin
            rd_d.word  = rd_bits;
            rd_d.valid = 1'b1;
            if (rd_q.rptr == PTR_W'(DEPTH - 1)) rd_d.rptr = '0;
            else                               rd_d.rptr = rd_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q.cnt   <= '0;
            rd_q.rptr  <= '0;
            rd_q.word  <= '0;
            rd_q.valid <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_ptr    = rd_q.rptr;
    assign out_word  = rd_q.word;
    assign out_valid = rd_q.valid;

endmodule

// File: rtl/lprx_top.sv
`timescale 1ns/1ps
module lprx_top #(
    parameter int LANES   = 8,
    parameter int LATENCY = 8,
    parameter int DEPTH   = 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_in,
    output logic [LANES-1:0] out_word,
    output logic             out_valid,
    output logic [LANES-1:0] lane_ready,
    output logic [LANES-1:0] lane_edge_fall
);

    logic [LANES-1:0] wr_en;
    logic [LANES-1:0] sel_bit;
    logic [LANES-1:0] rd_bits;
    logic [PTR_W-1:0] rd_ptr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lprx_lane_detect u_det (
            .clk       (clk),
            .rst       (rst),
            .din       (lane_in[g]),
            .ready     (lane_ready[g]),
            .edge_fall (lane_edge_fall[g]),
            .wr_en     (wr_en[g]),
            .sel_bit   (sel_bit[g])
        );

        lprx_lane_buf #(.DEPTH(DEPTH)) u_buf (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en[g]),
            .wr_bit (sel_bit[g]),
            .rd_ptr (rd_ptr),
            .rd_bit (rd_bits[g])
        );
    end

    lprx_read_ctrl #(
        .LANES   (LANES),
        .LATENCY (LATENCY),
        .DEPTH   (DEPTH)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .all_ready (&lane_ready),
        .rd_bits   (rd_bits),
        .rd_ptr    (rd_ptr),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/lprx_checker.sv
`timescale 1ns/1ps
module lprx_checker #(
    parameter int LANES   = 8,
    parameter int LATENCY = 8,
    localparam int CYC_W  = $clog2(LATENCY + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] lane_ready,
    input logic [LANES-1:0] lane_edge_fall,
    input logic             out_valid
);

    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)                                 cyc_q <= '0;
        else if (cyc_q != CYC_W'(LATENCY + 1))   cyc_q <= cyc_q + 1'b1;
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lane_ready & $past(lane_ready)) == $past(lane_ready))); // R4

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((lane_edge_fall ^ $past(lane_edge_fall)) & $past(lane_ready)) == '0)); // R5

    AST_VALID_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (&lane_ready)); // R8

    AST_VALID_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cyc_q == CYC_W'(LATENCY + 1))); // R7

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid); // R9

endmodule

bind lprx_top lprx_checker #(
    .LANES   (LANES),
    .LATENCY (LATENCY)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lane_ready     (lane_ready),
    .lane_edge_fall (lane_edge_fall),
    .out_valid      (out_valid)
);

// File: tb/lprx_top_tb_top.sv
`timescale 1ns/1ps
module lprx_top_tb_top;

    localparam int LANES   = 8;
    localparam int LATENCY = 8;
    localparam int DEPTH   = 8;
    localparam int PER_PS  = 4000;
    localparam int NPAY    = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] lanes = '0;
    logic [LANES-1:0] out_word;
    logic             out_valid;
    logic [LANES-1:0] lane_ready;
    logic [LANES-1:0] lane_edge_fall;

    int               checks   = 0;
    int               failures = 0;
    bit               finished = 1'b0;
    int               dly_ps [LANES];
    logic [LANES-1:0] pay [NPAY];

    always #2.0 clk = ~clk;

    lprx_top #(.LANES(LANES), .LATENCY(LATENCY), .DEPTH(DEPTH)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .lane_in        (lanes),
        .out_word       (out_word),
        .out_valid      (out_valid),
        .lane_ready     (lane_ready),
        .lane_edge_fall (lane_edge_fall)
    );

    function automatic bit exp_fall(int d);
        return (d % PER_PS) < (PER_PS / 2);
    endfunction

    function automatic int exp_lock(int d);
        return d / PER_PS + 1;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_lane(int li, bit shift);
        #(real'(dly_ps[li]) * 0.001);
        lanes[li] = 1'b1;
        for (int k = 0; k < NPAY; k++) begin
            #4.0;
            lanes[li] = pay[k][li];
            if (shift && k == 5) #2.0;
        end
    endtask

    task automatic run_case(bit hold0, bit shift, bit chk_data);
        logic [LANES-1:0] r_exp, e_exp;
        rst   = 1'b1;
        lanes = hold0 ? LANES'(1) : '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 word", 64'(out_word), 64'h0);
        chk("R1 valid", 64'(out_valid), 64'h0);
        chk("R1 ready", 64'(lane_ready), 64'h0);
        chk("R1 edge", 64'(lane_edge_fall), 64'h0);
        rst = 1'b0;
        @(posedge clk);   // edge 0
        for (int l = 0; l < LANES; l++) begin
            automatic int li = l;
            if (!(hold0 && li == 0)) fork drive_lane(li, shift); join_none
        end
        for (int c = 0; c < LATENCY + NPAY; c++) begin
            @(negedge clk);
            for (int i = 0; i < LANES; i++) begin
                r_exp[i] = !(hold0 && i == 0) && (c >= exp_lock(dly_ps[i]));
                e_exp[i] = r_exp[i] && exp_fall(dly_ps[i]);
            end
            if (c == 0) chk("R1 valid after release", 64'(out_valid), 64'h0);
            chk(hold0 ? "R2 R4 ready" : "R4 ready", 64'(lane_ready), 64'(r_exp));
            chk(shift ? "R5 edge" : "R3 edge", 64'(lane_edge_fall), 64'(e_exp));
            if (hold0) chk("R8 valid", 64'(out_valid), 64'h0);
            else       chk("R7 R9 valid", 64'(out_valid), 64'(c >= LATENCY));
            if (chk_data && c >= LATENCY)
                chk("R6 R7 word", 64'(out_word), 64'(pay[c - LATENCY]));
        end
        wait fork;
    endtask

    function automatic int rand_dly();
        int whole, frac;
        whole = int'($urandom % (LATENCY - 2));
        frac  = 200 + int'($urandom % 1600) + int'($urandom % 2) * (PER_PS / 2);
        return whole * PER_PS + frac;
    endfunction

    initial begin
        void'($urandom(32'd4711));

        // Random delays and payload
        for (int i = 0; i < LANES; i++) dly_ps[i] = rand_dly();
        for (int k = 0; k < NPAY; k++) pay[k] = LANES'($urandom);
        run_case(1'b0, 1'b0, 1'b1);

        // Directed: both halves, latest legal lane, alternating payload
        dly_ps = '{300, 2500, 1700, 3700, 23700, 10100, 14300, 22200};
        for (int k = 0; k < NPAY; k++)
            pay[k] = (k % 2 == 0) ? (LANES'(8'hA5) ^ LANES'(k)) : ~LANES'(1 << (k % LANES));
        run_case(1'b0, 1'b0, 1'b1);

        // Second random set
        for (int i = 0; i < LANES; i++) dly_ps[i] = rand_dly();
        for (int k = 0; k < NPAY; k++) pay[k] = LANES'($urandom);
        run_case(1'b0, 1'b0, 1'b1);

        // Lane 0 high from reset: never trains, output stays invalid
        for (int i = 0; i < LANES; i++) dly_ps[i] = rand_dly();
        run_case(1'b1, 1'b0, 1'b0);

        // Arrival time moves half a period after training: edge choice held
        for (int i = 0; i < LANES; i++) dly_ps[i] = rand_dly();
        run_case(1'b0, 1'b1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000.0;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule